// File: doc/BRIEF.md
# Serial Chain Configuration Loader

This block is the receiving end of a serial configuration port. A host, a download cable or an upstream device of the same kind drives one data bit per rising edge of the shared configuration clock. The block sits in a waiting state with the line idle high. The first low bit it sees after its initialisation window marks the start of its image. It then takes exactly `IMAGE_BITS` bits, packs them into bytes and writes each byte to the configuration storage at consecutive addresses.

After the last bit of its own image it stops taking data. From then on it copies every incoming bit to its serial output, one clock later, using the same clock edge. A second device on that output sees an idle-high line, then the start bit and image that the host sent for it. Each device in a chain therefore picks its own slice from one concatenated stream. Devices whose inputs share one line all load the same image in the same cycles.

An active-low program input restarts the block. While it is asserted, and for `INIT_CLKS` clocks after it is released, the init-ready output stays low and incoming data is ignored.

Top module: `cfg_chain_rx`

## Requirements
- R1: While `prog_n` is sampled low, the block is reset: from the following clock edge `done` is 0, `init_rdy` is 0, `sdo` is 1 and `wr_en` is 0.
- R2: `init_rdy` rises exactly `INIT_CLKS` clock edges after `prog_n` is first sampled high, and it then stays high until the next program pulse.
- R3: A bit is sampled on an edge at which `init_rdy` is already high. If that bit is 0 and loading has not yet started, it is taken as the start marker and is not stored. Bits sampled before that point, whether 0 or 1, are ignored, and so are 1 bits that come after it.
- R4: The `IMAGE_BITS` bits after the start marker are packed most significant bit first. The first bit of each group of eight lands in `wr_data[7]` and the eighth lands in `wr_data[0]`.
- R5: For each completed byte, `wr_en` is high for exactly one cycle, starting on the edge that samples the byte's eighth bit. `wr_addr` is 0 for the first byte and goes up by one for each byte after it.
- R6: `done` rises on the edge that samples the last image bit and stays high until `prog_n` is asserted.
- R7: While the block is not forwarding, `sdo` is 1.
- R8: Once `done` is high, `sdo` after each edge equals the `sdi` value sampled at that edge, so the output trails the input by one clock.
- R9: After the final byte write, no further write strobe occurs until the next program pulse.
- R10: A second instance whose `sdi` is driven by the first instance's `sdo` stores the image that follows the first instance's slice in the stream.
- R11: Two instances fed the same `sdi` and `prog_n` issue identical writes in identical cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock, rising edge active |
| prog_n | input | 1 | Active-low program/restart, sampled synchronously |
| sdi | input | 1 | Serial configuration data in |
| sdo | output | 1 | Registered pass-through to the next device; idle high |
| done | output | 1 | Own image completely received |
| init_rdy | output | 1 | Initialisation window over; data may be accepted |
| wr_en | output | 1 | Byte write strobe to configuration storage |
| wr_addr | output | ADDR_W | Byte address of the current write |
| wr_data | output | 8 | Byte being written |

## Verification
Every result is one register stage away from the input that causes it. The write strobe, the byte, `done` and the forwarded `sdo` bit all appear after the edge that samples the deciding `sdi` bit. `init_rdy` appears `INIT_CLKS` edges after `prog_n` is released. The bench drives inputs on falling edges and keeps a behavioural model per instance that is advanced once per driven cycle. At the next falling edge it compares every output against that model, so each expected value is checked exactly one edge after its cause. For the chained instance, the model's input is the upstream model's pre-edge `sdo`, which reproduces the one-clock shift through the chain.

// File: rtl/cfg_chain_pkg.sv
package cfg_chain_pkg;

  typedef enum logic [1:0] {
    FS_WAIT = 2'd0,
    FS_LOAD = 2'd1,
    FS_FWD  = 2'd2
  } frame_state_e;

  function automatic int image_bytes(input int bits);
    return bits / 8;
  endfunction

  function automatic int addr_width(input int bits);
    return (bits / 8 > 1) ? $clog2(bits / 8) : 1;
  endfunction

  function automatic logic [7:0] push_bit(input logic [7:0] acc, input logic b);
    return {acc[6:0], b};
  endfunction

endpackage

// File: rtl/cfg_init_timer.sv
module cfg_init_timer #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic prog_n,
  output logic ready
);
  localparam int W = $clog2(HOLD + 1);

  logic [W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!prog_n)
      remain <= W'(HOLD);
    else if (remain != '0)
      remain <= remain - 1'b1;
  end

  assign ready = (remain == '0);

  assert_init_hold_R2: assert property (@(posedge clk) disable iff (!prog_n)
    $past(!prog_n) |-> !ready);

  assert_init_stay_R2: assert property (@(posedge clk) disable iff (!prog_n)
    ready |=> ready);

endmodule

// File: rtl/cfg_frame_ctrl.sv
module cfg_frame_ctrl
  import cfg_chain_pkg::*;
#(
  parameter int IMAGE_BITS = 64
) (
  input  logic clk,
  input  logic prog_n,
  input  logic ready,
  input  logic sdi,
  output logic shift_en,
  output logic done,
  output logic sdo
);
  localparam int CW = $clog2(IMAGE_BITS + 1);

  frame_state_e  state;
  logic [CW-1:0] nbits;
  logic          start_seen;
  logic          last_bit;

  assign start_seen = (state == FS_WAIT) && ready && !sdi;
  assign last_bit   = (state == FS_LOAD) && (nbits == CW'(IMAGE_BITS - 1));

  always_ff @(posedge clk) begin
    if (!prog_n) begin
      state <= FS_WAIT;
      nbits <= '0;
      sdo   <= 1'b1;
    end else begin
      sdo <= (state == FS_FWD) ? sdi : 1'b1;
      if (start_seen) begin
        state <= FS_LOAD;
        nbits <= '0;
      end else if (state == FS_LOAD) begin
        nbits <= nbits + 1'b1;
        if (last_bit) state <= FS_FWD;
      end
    end
  end

  assign shift_en = (state == FS_LOAD);
  assign done     = (state == FS_FWD);

  assert_sdo_idle_R7: assert property (@(posedge clk) disable iff (!prog_n)
    (state != FS_FWD) |=> sdo);

  assert_sdo_copy_R8: assert property (@(posedge clk) disable iff (!prog_n)
    done |=> (sdo == $past(sdi)));

  assert_done_hold_R6: assert property (@(posedge clk) disable iff (!prog_n)
    done |=> done);

  assert_wait_gate_R3: assert property (@(posedge clk) disable iff (!prog_n)
    ((state == FS_WAIT) && (!ready || sdi)) |=> (state == FS_WAIT));

endmodule

// File: rtl/cfg_byte_packer.sv
module cfg_byte_packer
  import cfg_chain_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              prog_n,
  input  logic              shift_en,
  input  logic              sdi,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  logic [2:0]        phase;
  logic [7:0]        acc;
  logic [ADDR_W-1:0] next_addr;
  logic              byte_full;

  assign byte_full = shift_en && (phase == 3'd7);

  always_ff @(posedge clk) begin
    if (!prog_n) begin
      phase     <= '0;
      acc       <= '0;
      next_addr <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_en <= byte_full;
      if (shift_en) begin
        acc   <= push_bit(acc, sdi);
        phase <= phase + 1'b1;
      end
      if (byte_full) begin
        wr_data   <= push_bit(acc, sdi);
        wr_addr   <= next_addr;
        next_addr <= next_addr + 1'b1;
      end
    end
  end

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!prog_n)
    wr_en |=> !wr_en);

  assert_lsb_last_R4: assert property (@(posedge clk) disable iff (!prog_n)
    byte_full |=> (wr_en && (wr_data[0] == $past(sdi))));

endmodule

// File: rtl/cfg_chain_rx.sv
module cfg_chain_rx
  import cfg_chain_pkg::*;
#(
  parameter  int IMAGE_BITS = 64,
  parameter  int INIT_CLKS  = 4,
  localparam int ADDR_W     = addr_width(IMAGE_BITS)
) (
  input  logic              clk,
  input  logic              prog_n,
  input  logic              sdi,
  output logic              sdo,
  output logic              done,
  output logic              init_rdy,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  logic shift_en;

  cfg_init_timer #(.HOLD(INIT_CLKS)) u_timer (
    .clk    (clk),
    .prog_n (prog_n),
    .ready  (init_rdy)
  );

  cfg_frame_ctrl #(.IMAGE_BITS(IMAGE_BITS)) u_ctrl (
    .clk      (clk),
    .prog_n   (prog_n),
    .ready    (init_rdy),
    .sdi      (sdi),
    .shift_en (shift_en),
    .done     (done),
    .sdo      (sdo)
  );

  cfg_byte_packer #(.ADDR_W(ADDR_W)) u_pack (
    .clk      (clk),
    .prog_n   (prog_n),
    .shift_en (shift_en),
    .sdi      (sdi),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  assert_quiet_after_done_R9: assert property (@(posedge clk) disable iff (!prog_n)
    (done && $past(done)) |-> !wr_en);

  assert_no_load_before_init_R3: assert property (@(posedge clk) disable iff (!prog_n)
    !init_rdy |-> (!shift_en && !done));

endmodule

// File: tb/cfg_chain_rx_bench.sv
module cfg_chain_rx_bench;
  localparam int IMAGE_BITS = 32;
  localparam int INIT_CLKS  = 5;
  localparam int NBYTES     = IMAGE_BITS / 8;
  localparam int AW         = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic prog_n = 1'b0;
  logic sdi    = 1'b1;

  logic          o_sdo [3];
  logic          o_done[3];
  logic          o_rdy [3];
  logic          o_wr  [3];
  logic [AW-1:0] o_wa  [3];
  logic [7:0]    o_wd  [3];

  cfg_chain_rx #(.IMAGE_BITS(IMAGE_BITS), .INIT_CLKS(INIT_CLKS)) u_cfg_chain_rx (
    .clk(clk), .prog_n(prog_n), .sdi(sdi), .sdo(o_sdo[0]), .done(o_done[0]),
    .init_rdy(o_rdy[0]), .wr_en(o_wr[0]), .wr_addr(o_wa[0]), .wr_data(o_wd[0]));

  cfg_chain_rx #(.IMAGE_BITS(IMAGE_BITS), .INIT_CLKS(INIT_CLKS)) u_cfg_chain_rx_next (
    .clk(clk), .prog_n(prog_n), .sdi(o_sdo[0]), .sdo(o_sdo[1]), .done(o_done[1]),
    .init_rdy(o_rdy[1]), .wr_en(o_wr[1]), .wr_addr(o_wa[1]), .wr_data(o_wd[1]));

  cfg_chain_rx #(.IMAGE_BITS(IMAGE_BITS), .INIT_CLKS(INIT_CLKS)) u_cfg_chain_rx_twin (
    .clk(clk), .prog_n(prog_n), .sdi(sdi), .sdo(o_sdo[2]), .done(o_done[2]),
    .init_rdy(o_rdy[2]), .wr_en(o_wr[2]), .wr_addr(o_wa[2]), .wr_data(o_wd[2]));

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // behavioural model, one slot per instance
  int   m_hold[3];
  int   m_st  [3];   // 0 waiting, 1 loading, 2 forwarding
  int   m_nb  [3];
  int   m_addr[3];
  bit   m_sdo [3];
  bit   m_wr  [3];
  int   m_wa  [3];
  int   m_wd  [3];
  bit   m_q   [3][$];

  int   mem   [3][NBYTES];
  int   nwr   [3];
  int   first_wd[3];

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_step(input int d, input bit p, input bit s);
    int old_st;
    bit rdy;
    int v;
    if (!p) begin
      m_hold[d] = INIT_CLKS; m_st[d] = 0; m_nb[d] = 0; m_addr[d] = 0;
      m_sdo[d] = 1'b1; m_wr[d] = 1'b0; m_q[d].delete();
    end else begin
      old_st = m_st[d];
      rdy = (m_hold[d] == 0);
      if (m_hold[d] > 0) m_hold[d]--;
      m_wr[d]  = 1'b0;
      m_sdo[d] = (old_st == 2) ? s : 1'b1;
      if (old_st == 0 && rdy && !s) m_st[d] = 1;
      else if (old_st == 1) begin
        m_q[d].push_back(s);
        m_nb[d]++;
        if (m_q[d].size() == 8) begin
          v = 0;
          foreach (m_q[d][i]) v = v * 2 + int'(m_q[d][i]);
          m_wr[d] = 1'b1; m_wd[d] = v; m_wa[d] = m_addr[d];
          m_addr[d]++;
          m_q[d].delete();
        end
        if (m_nb[d] == IMAGE_BITS) m_st[d] = 2;
      end
    end
  endtask

  task automatic compare();
    for (int d = 0; d < 3; d++) begin
      chk($sformatf("R2 init_rdy dev%0d", d), int'(o_rdy[d]), int'(m_hold[d] == 0));
      chk($sformatf("R6 done dev%0d", d), int'(o_done[d]), int'(m_st[d] == 2));
      chk($sformatf("R7/R8 sdo dev%0d", d), int'(o_sdo[d]), int'(m_sdo[d]));
      chk($sformatf("R5 wr_en dev%0d", d), int'(o_wr[d]), int'(m_wr[d]));
      if (o_wr[d] && m_wr[d]) begin
        chk($sformatf("R5 wr_addr dev%0d", d), int'(o_wa[d]), m_wa[d]);
        chk($sformatf("R4 wr_data dev%0d", d), int'(o_wd[d]), m_wd[d]);
      end
      if (o_wr[d]) begin
        if (nwr[d] == 0) first_wd[d] = int'(o_wd[d]);
        mem[d][o_wa[d]] = int'(o_wd[d]);
        nwr[d]++;
      end
    end
    chk("R11 twin writes", int'({o_wr[0], o_wa[0], o_wd[0]}), int'({o_wr[2], o_wa[2], o_wd[2]}));
  endtask

  task automatic tick(input bit p, input bit s);
    bit up_sdo;
    @(negedge clk);
    compare();
    prog_n = p;
    sdi    = s;
    up_sdo = m_sdo[0];
    model_step(0, p, s);
    model_step(1, p, up_sdo);
    model_step(2, p, s);
  endtask

  task automatic send_word(input logic [IMAGE_BITS-1:0] w);
    for (int i = IMAGE_BITS - 1; i >= 0; i--) tick(1'b1, w[i]);
  endtask

  task automatic clear_log();
    for (int d = 0; d < 3; d++) begin
      nwr[d] = 0;
      first_wd[d] = -1;
      for (int b = 0; b < NBYTES; b++) mem[d][b] = -1;
    end
  endtask

  task automatic check_image(input int d, input logic [IMAGE_BITS-1:0] w, input string tag);
    for (int b = 0; b < NBYTES; b++)
      chk($sformatf("%s dev%0d byte%0d", tag, d, b), mem[d][b],
          int'(w[IMAGE_BITS-1-8*b -: 8]));
    chk($sformatf("R9 write count dev%0d", d), nwr[d], NBYTES);
  endtask

  task automatic run_load(input logic [IMAGE_BITS-1:0] a, input logic [IMAGE_BITS-1:0] b);
    clear_log();
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b1);
    @(posedge clk);
    #2;
    for (int d = 0; d < 3; d++) begin
      chk($sformatf("R1 done reset dev%0d", d), int'(o_done[d]), 0);
      chk($sformatf("R1 init_rdy reset dev%0d", d), int'(o_rdy[d]), 0);
      chk($sformatf("R1 sdo reset dev%0d", d), int'(o_sdo[d]), 1);
      chk($sformatf("R1 wr_en reset dev%0d", d), int'(o_wr[d]), 0);
    end
    // zeros during the init window must be ignored (R3)
    for (int i = 0; i < INIT_CLKS; i++) tick(1'b1, 1'b0);
    for (int i = 0; i < 6; i++) tick(1'b1, 1'b1);
    tick(1'b1, 1'b0);
    send_word(a);
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b1);
    tick(1'b1, 1'b0);
    send_word(b);
    for (int i = 0; i < 20; i++) tick(1'b1, i[0]);
    tick(1'b1, 1'b1);
    chk("R3 first byte dev0", first_wd[0], int'(a[IMAGE_BITS-1 -: 8]));
    check_image(0, a, "R4");
    check_image(1, b, "R10");
    check_image(2, a, "R11");
  endtask

  initial begin
    for (int d = 0; d < 3; d++) model_step(d, 1'b0, 1'b1);
    clear_log();
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b1);
    run_load(32'hA5C3_0F81, 32'h5E96_00FF);
    run_load(32'h0123_4567, 32'hFEDC_BA98);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule